// File: doc/BRIEF.md
# HDLC Line-Condition Monitor and Interrupt Flag Unit

This unit monitors the received serial bit stream of an HDLC link for three line conditions. An abort is a run of seven ONE bits. A go-ahead is a ZERO followed by seven ONE bits. An idle channel is a run of fifteen or more ONE bits. The unit also takes single-cycle event pulses from the receive FIFO (overflow) and from the transmitter (underrun).

All five conditions are latched into an interrupt flag register. An interrupt enable register masks that flag register. The open-drain-style active-low interrupt line is pulled low whenever an enabled flag is set. A flag whose enable bit is clear still latches, but it has no effect on the interrupt line.

A second, read-only status byte gives the host a summary view. It mirrors the overflow, underrun and go-ahead flags. It holds its own sticky abort bit and shows the live idle condition and the state of the interrupt line. Host reads are strobes. A flag read clears the flag register. A status read clears only the sticky abort bit.

Top module: `hdlc_line_irq`

## Requirements
- R1: The seventh consecutive valid ONE bit sets flag bit 1 (abort) and status bit 4 (abort). Both are visible after the clock edge that samples that bit.
- R2: The status abort bit (status bit 4) is cleared only by a status read strobe. A flag read strobe leaves it unchanged.
- R3: Status bit 2 (idle) is HIGH while the run of consecutive valid ONE bits is 15 or longer, and it is LOW at 14. Flag bit 2 (idle) is set when the run reaches 15. A valid ZERO bit drops status bit 2 at the next edge.
- R4: Flag bit 0 (go-ahead) is set when a run of seven ONE bits follows a ZERO. A run of seven ONE bits that starts at the beginning of the stream, with no ZERO seen since reset, sets abort but not go-ahead.
- R5: A receive-overflow pulse sets flag bit 3, and a transmit-underrun pulse sets flag bit 4. Status bits 7, 6 and 5 mirror flag bits 3, 4 and 0.
- R6: A flag read strobe clears every flag bit at the next edge, unless the same bit has an event in that cycle. A status read strobe leaves the flag register unchanged.
- R7: An event that arrives in the same cycle as the clearing read of its bit leaves that bit set.
- R8: irq_n is LOW exactly when some flag bit and its enable bit are both set. Flags whose enable bit is clear still latch.
- R9: Status bit 3 reads HIGH when irq_n is LOW, and LOW otherwise. Status bits 1 and 0 always read 0 and 1.
- R10: After reset the flag and enable registers are zero, irq_n is HIGH and the status byte reads 8'h01.
- R11: A valid ZERO bit restarts the run count. Six ONEs, a ZERO and six more ONEs produce no abort, go-ahead or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit_vld | input | 1 | Qualifies rx_bit for this cycle |
| rx_bit | input | 1 | Received (unstuffed) serial bit |
| rx_ovf_evt | input | 1 | Receive FIFO overflow pulse |
| tx_urun_evt | input | 1 | Transmit underrun pulse |
| flag_rd | input | 1 | Flag register read strobe (clears flags) |
| stat_rd | input | 1 | Status register read strobe (clears status abort) |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 5 | Enable register write data |
| flag_rdata | output | 5 | Flag register: bit0 go-ahead, bit1 abort, bit2 idle, bit3 rx overflow, bit4 tx underrun |
| en_rdata | output | 5 | Enable register contents |
| stat_rdata | output | 8 | Status byte: 7 ovf, 6 urun, 5 go-ahead, 4 abort, 3 irq, 2 idle, 1 low, 0 high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets these corner cases:
- A run of seven ONEs right after reset, where a detector that ignores the preceding ZERO would also report a go-ahead.
- A run of exactly fourteen ONEs, where an off-by-one idle threshold would show idle early.
- A broken run of six plus six ONEs, where a counter that does not restart on ZERO would report an abort.
- A clearing read that lands in the same cycle as an event, where a design that gives the clear priority would lose the event.
- Cross-clearing between the two reads, where a flag read would wrongly drop the status abort bit or a status read would wrongly drop flags.
- Masked flags, where a design with the wrong masking would pull irq_n low, or would fail to latch a flag whose enable bit is clear.

// File: rtl/hdlc_lc_pkg.sv
// Package: shared constants for the HDLC line-condition monitor.
// Assumes: flag positions below are the host-visible flag register layout.
package hdlc_lc_pkg;
    localparam int NUM_FLAGS  = 5;
    localparam int FLG_GA     = 0;
    localparam int FLG_ABORT  = 1;
    localparam int FLG_IDLE   = 2;
    localparam int FLG_RXOVF  = 3;
    localparam int FLG_TXURUN = 4;
    localparam int STAT_W     = 8;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/hdlc_lc_run_detect.sv
// Module: counts consecutive ONE bits on the received stream and emits
// single-cycle abort, go-ahead and idle-entry events plus a live idle level.
// Assumes: rx_bit is already unstuffed; ABORT_RUN < IDLE_RUN; the counter
// saturates at IDLE_RUN so long idle periods never wrap.
module hdlc_lc_run_detect #(
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_val,
    output logic abort_evt,
    output logic ga_evt,
    output logic idle_evt,
    output logic idle_live
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] ABORT_M1 = RUN_W'(ABORT_RUN - 1);
    localparam logic [RUN_W-1:0] IDLE_M1  = RUN_W'(IDLE_RUN - 1);
    localparam logic [RUN_W-1:0] IDLE_MAX = RUN_W'(IDLE_RUN);

    logic [RUN_W-1:0] run_q;
    logic             zero_seen_q;
    logic             one_bit;

    assign one_bit = bit_vld && bit_val;

    // Run-of-ONEs counter: restart on ZERO, saturate at the idle length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_vld) begin
            if (!bit_val) begin
                run_q <= '0;
            end else if (run_q != IDLE_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Remembers that a ZERO has preceded the current run (go-ahead qualifier).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_seen_q <= 1'b0;
        end else if (bit_vld && !bit_val) begin
            zero_seen_q <= 1'b1;
        end
    end

    // Event decode on the bit that completes each run length.
    always_comb begin
        abort_evt = one_bit && (run_q == ABORT_M1);
        ga_evt    = abort_evt && zero_seen_q;
        idle_evt  = one_bit && (run_q == IDLE_M1);
        idle_live = (run_q == IDLE_MAX);
    end

    p_idle_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_val) |=> !idle_live);

    p_idle_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_live) |-> $past(idle_evt));

    p_no_abort_after_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_val) |=> !abort_evt);
endmodule

// File: rtl/hdlc_lc_flag_bank.sv
// Module: interrupt flag register and its enable (mask) register.
// Assumes: set_vec bits are single-cycle pulses; a set in the same cycle as
// a clearing read wins, so no event is dropped.
module hdlc_lc_flag_bank #(
    parameter int NFLAG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic             clr_rd,
    input  logic             en_wr,
    input  logic [NFLAG-1:0] en_wdata,
    output logic [NFLAG-1:0] flag_q,
    output logic [NFLAG-1:0] en_q
);
    // Enable register: plain host-writable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // One sticky flag: set has priority over the read-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_rd) begin
                flag_q[i] <= 1'b0;
            end
        end

        p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);

        p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_rd && !set_vec[i]) |=> !flag_q[i]);

        p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_rd && !set_vec[i]) |=> $stable(flag_q[i]));
    end
endmodule

// File: rtl/hdlc_lc_status.sv
// Module: assembles the read-only status byte and keeps its own sticky
// abort bit, which only a status read clears.
// Assumes: flag positions from hdlc_lc_pkg; irq_act is HIGH when irq_n is LOW.
module hdlc_lc_status
    import hdlc_lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_evt,
    input  logic              stat_rd,
    input  flag_vec_t         flags,
    input  logic              irq_act,
    input  logic              idle_live,
    output logic [STAT_W-1:0] stat
);
    logic abort_st_q;

    // Sticky abort status: event wins over a same-cycle status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_st_q <= 1'b0;
        end else if (abort_evt) begin
            abort_st_q <= 1'b1;
        end else if (stat_rd) begin
            abort_st_q <= 1'b0;
        end
    end

    // Status byte layout, MSB first.
    always_comb begin
        stat = {flags[FLG_RXOVF], flags[FLG_TXURUN], flags[FLG_GA],
                abort_st_q, irq_act, idle_live, 1'b0, 1'b1};
    end

    p_abort_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> stat[4]);

    p_abort_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !abort_evt) |=> !stat[4]);

    p_abort_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !abort_evt) |=> $stable(abort_st_q));
endmodule

// File: rtl/hdlc_line_irq.sv
// Module: top of the HDLC line-condition and interrupt unit. Joins the run
// detector, flag/enable bank and status byte, and drives the active-low IRQ.
// Assumes: event inputs and read strobes are single-cycle; IRQ is a
// combinational function of registered flags and enables (no glitch source).
module hdlc_line_irq
    import hdlc_lc_pkg::*;
#(
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit_vld,
    input  logic                 rx_bit,
    input  logic                 rx_ovf_evt,
    input  logic                 tx_urun_evt,
    input  logic                 flag_rd,
    input  logic                 stat_rd,
    input  logic                 en_wr,
    input  logic [NUM_FLAGS-1:0] en_wdata,
    output logic [NUM_FLAGS-1:0] flag_rdata,
    output logic [NUM_FLAGS-1:0] en_rdata,
    output logic [STAT_W-1:0]    stat_rdata,
    output logic                 irq_n
);
    logic      abort_evt;
    logic      ga_evt;
    logic      idle_evt;
    logic      idle_live;
    flag_vec_t set_vec;
    logic      irq_act;

    hdlc_lc_run_detect #(
        .ABORT_RUN (ABORT_RUN),
        .IDLE_RUN  (IDLE_RUN)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (rx_bit_vld),
        .bit_val   (rx_bit),
        .abort_evt (abort_evt),
        .ga_evt    (ga_evt),
        .idle_evt  (idle_evt),
        .idle_live (idle_live)
    );

    // Gather all event sources into flag positions.
    always_comb begin
        set_vec             = '0;
        set_vec[FLG_GA]     = ga_evt;
        set_vec[FLG_ABORT]  = abort_evt;
        set_vec[FLG_IDLE]   = idle_evt;
        set_vec[FLG_RXOVF]  = rx_ovf_evt;
        set_vec[FLG_TXURUN] = tx_urun_evt;
    end

    hdlc_lc_flag_bank #(
        .NFLAG (NUM_FLAGS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_rd   (flag_rd),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .flag_q   (flag_rdata),
        .en_q     (en_rdata)
    );

    // Interrupt request: any enabled flag pulls the line low.
    always_comb begin
        irq_act = |(flag_rdata & en_rdata);
        irq_n   = !irq_act;
    end

    hdlc_lc_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_evt (abort_evt),
        .stat_rd   (stat_rd),
        .flags     (flag_rdata),
        .irq_act   (irq_act),
        .idle_live (idle_live),
        .stat      (stat_rdata)
    );

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata == '0) |-> irq_n);

    p_irq_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata[FLG_RXOVF] && en_rdata[FLG_RXOVF]) |-> !irq_n);

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[1:0] == 2'b01);
endmodule

// File: tb/test_hdlc_line_irq.sv
module test_hdlc_line_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bv = 1'b0, bb = 1'b0, ovf = 1'b0, ur = 1'b0;
    logic       frd = 1'b0, srd = 1'b0, ew = 1'b0;
    logic [4:0] ewd = '0;
    logic [4:0] flag_rdata, en_rdata;
    logic [7:0] stat_rdata;
    logic       irq_n;

    int errors = 0;
    int checks = 0;

    // Reference model state
    int         m_run = 0;
    bit         m_zero = 0;
    logic [4:0] m_flg = '0;
    logic [4:0] m_en = '0;
    bit         m_abs = 0;

    always #2.5 clk = ~clk;

    hdlc_line_irq i_hdlc_line_irq (
        .clk(clk), .rst_n(rst_n), .rx_bit_vld(bv), .rx_bit(bb),
        .rx_ovf_evt(ovf), .tx_urun_evt(ur), .flag_rd(frd), .stat_rd(srd),
        .en_wr(ew), .en_wdata(ewd), .flag_rdata(flag_rdata),
        .en_rdata(en_rdata), .stat_rdata(stat_rdata), .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference updated at each rising edge.
    always @(posedge clk) begin
        logic [4:0] s;
        bit ab;
        if (!rst_n) begin
            m_run = 0; m_zero = 0; m_flg = '0; m_en = '0; m_abs = 0;
        end else begin
            s = '0; ab = 0;
            if (bv) begin
                if (!bb) begin
                    m_run = 0; m_zero = 1;
                end else begin
                    m_run++;
                    if (m_run == 7) begin s[1] = 1; ab = 1; if (m_zero) s[0] = 1; end
                    if (m_run == 15) s[2] = 1;
                end
            end
            if (ovf) s[3] = 1;
            if (ur) s[4] = 1;
            m_flg = (frd ? 5'd0 : m_flg) | s;
            m_abs = (srd ? 1'b0 : m_abs) | ab;
            if (ew) m_en = ewd;
        end
    end

    // Per-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic mirq;
            mirq = |(m_flg & m_en);
            check({3'b0, flag_rdata}, {3'b0, m_flg}, "R6 model flags");
            check({7'b0, irq_n}, {7'b0, !mirq}, "R8 model irq");
            check(stat_rdata, {m_flg[3], m_flg[4], m_flg[0], m_abs, mirq,
                               (m_run >= 15), 1'b0, 1'b1}, "R9 model status");
        end
    end

    task automatic cyc(input logic v, input logic b, input logic o, input logic u,
                       input logic fr, input logic sr, input logic w, input logic [4:0] wd);
        @(posedge clk);
        #1;
        bv = v; bb = b; ovf = o; ur = u; frd = fr; srd = sr; ew = w; ewd = wd;
    endtask

    task automatic nop();
        cyc(0, 0, 0, 0, 0, 0, 0, 5'd0);
    endtask

    task automatic bits(input int n, input logic b);
        for (int k = 0; k < n; k++) cyc(1, b, 0, 0, 0, 0, 0, 5'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        nop();
        // R10: reset state
        check({3'b0, flag_rdata}, 8'h00, "R10 flags");
        check({3'b0, en_rdata}, 8'h00, "R10 enables");
        check({7'b0, irq_n}, 8'h01, "R10 irq_n");
        check(stat_rdata, 8'h01, "R10 status");

        // R4: seven ONEs at start of stream, no ZERO before: abort only
        bits(7, 1); nop();
        check({3'b0, flag_rdata}, 8'h02, "R4 no go-ahead at stream start");
        check(stat_rdata, 8'h11, "R4 status");
        cyc(0, 0, 0, 0, 1, 1, 0, 5'd0); nop();
        check(stat_rdata, 8'h01, "R6 both reads clear");

        // R1/R4: ZERO then seven ONEs
        bits(1, 0); bits(7, 1); nop();
        check({3'b0, flag_rdata}, 8'h03, "R1 abort and go-ahead flags");
        check(stat_rdata, 8'h31, "R1 status abort and go-ahead");
        check({7'b0, irq_n}, 8'h01, "R8 masked flags keep irq high");

        // R3: fourteen ONEs not idle, fifteen idle
        bits(7, 1); nop();
        check(stat_rdata, 8'h31, "R3 no idle at 14");
        bits(1, 1); nop();
        check(stat_rdata, 8'h35, "R3 idle at 15");
        check({3'b0, flag_rdata}, 8'h07, "R3 idle flag");
        bits(3, 1); nop();
        check({3'b0, flag_rdata}, 8'h07, "R3 idle persists");
        bits(1, 0); nop();
        check(stat_rdata, 8'h31, "R3 zero drops idle");

        // R2: status read clears abort only
        cyc(0, 0, 0, 0, 0, 1, 0, 5'd0); nop();
        check(stat_rdata, 8'h21, "R2 status read clears abort only");
        check({3'b0, flag_rdata}, 8'h07, "R6 status read keeps flags");
        cyc(0, 0, 0, 0, 1, 0, 0, 5'd0); nop();
        check({3'b0, flag_rdata}, 8'h00, "R6 flag read clears");
        check(stat_rdata, 8'h01, "R6 status after flag read");

        // R2: flag read does not clear status abort
        bits(7, 1); nop();
        cyc(0, 0, 0, 0, 1, 0, 0, 5'd0); nop();
        check(stat_rdata, 8'h11, "R2 flag read keeps status abort");
        cyc(0, 0, 0, 0, 0, 1, 0, 5'd0); nop();
        check(stat_rdata, 8'h01, "R2 status read clears");
        bits(1, 0);

        // R11: broken run
        bits(6, 1); bits(1, 0); bits(6, 1); nop();
        check({3'b0, flag_rdata}, 8'h00, "R11 no abort on broken run");
        check(stat_rdata, 8'h01, "R11 status");
        bits(1, 0);

        // R5: FIFO and transmitter events
        cyc(0, 0, 1, 0, 0, 0, 0, 5'd0); nop();
        check({3'b0, flag_rdata}, 8'h08, "R5 overflow flag");
        check(stat_rdata, 8'h81, "R5 overflow status");
        cyc(0, 0, 0, 1, 0, 0, 0, 5'd0); nop();
        check({3'b0, flag_rdata}, 8'h18, "R5 underrun flag");
        check(stat_rdata, 8'hC1, "R5 underrun status");
        check({7'b0, irq_n}, 8'h01, "R8 masked");

        // R8/R9: enable overflow source
        cyc(0, 0, 0, 0, 0, 0, 1, 5'h08); nop();
        check({7'b0, irq_n}, 8'h00, "R8 enabled flag drives irq");
        check(stat_rdata, 8'hC9, "R9 irq status bit");

        // R7: event coincides with clearing read
        cyc(0, 0, 1, 0, 1, 0, 0, 5'd0); nop();
        check({3'b0, flag_rdata}, 8'h08, "R7 overflow survives read");
        check(stat_rdata, 8'h89, "R7 status");
        cyc(0, 0, 0, 0, 1, 0, 0, 5'd0); nop();
        check({7'b0, irq_n}, 8'h01, "R8 irq released");
        check(stat_rdata, 8'h01, "R6 cleared");

        // R7: abort event coincides with status read
        cyc(0, 0, 0, 0, 0, 0, 1, 5'h1F);
        bits(6, 1);
        cyc(1, 1, 0, 0, 0, 1, 0, 5'd0); nop();
        check(stat_rdata, 8'h39, "R7 abort survives status read");
        check({3'b0, flag_rdata}, 8'h03, "R7 flags");

        repeat (3) nop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule